// File: doc/BRIEF.md
# Test Instruction Decoder and Data Path Selector

This block sits behind a standard test access port state machine. The state machine passes in one-cycle state strobes for capture, shift and update of the instruction path, capture and shift of the data path, and the test-logic-reset state. From these strobes the block keeps a shifted instruction and an active instruction. It decodes the active instruction into two things: which test data register sits between the serial input and the serial output, and how the chip's output pins behave.

The block holds two of the test data registers itself. One is the single-bit pass-through register. The other is the 32-bit identification register, which is shared by the identify and user-code instructions and differs only in the word it captures. The boundary register lives outside the block. The block selects it through `bsr_sel` and reads its serial output on `bsr_so`. The serial output is retimed on the falling test clock edge and is enabled only while a shift state is active.

Top module: `tapdec_top`

## Requirements
- R1: An asynchronous low level on `trst_n`, or a rising test clock edge with `tlr` high, makes the identify code 4'b0010 the active instruction. After that, a data capture and shift reads out the identification word without any instruction being loaded. After reset, `tdo_oe`, `bsr_sel` and `pin_mode` are all 0.
- R2: Capture-IR loads 4'b0001 into the instruction shift register, and Shift-IR moves it out least significant bit first while TDI fills from the top. The active instruction and `pin_mode` stay unchanged until the edge on which `update_ir` is high.
- R3: The code 4'b1111, and every code with no assigned meaning (for example 4'b1010), selects the single-bit path. That path captures 0 in Capture-DR and delays TDI by one shift cycle. `pin_mode` is 0 and `bsr_sel` is 0.
- R4: The identify code 4'b0010 captures the word {version[3:0], part[15:0], maker[10:0], 1'b1}, bits 31 down to 0. It is shifted out bit 0 first.
- R5: The user-code instruction 4'b0011 selects the same 32-bit register, but Capture-DR loads the `user_code` input into it.
- R6: The external-test code 4'b0000 sets `bsr_sel`=1 and `pin_mode`=2'b01 (pins driven from the boundary register). The sample code 4'b0001 sets `bsr_sel`=1 and `pin_mode`=2'b00 (pins under system control). With either code, TDO follows `bsr_so`.
- R7: The clamp code 4'b0100 sets `pin_mode`=2'b01 and `bsr_sel`=0, and the serial path runs through the single-bit register.
- R8: The float code 4'b0101 sets `pin_mode`=2'b10 (all outputs high impedance), and the serial path runs through the single-bit register.
- R9: `tdo` and `tdo_oe` change only on the falling test clock edge. `tdo_oe` is 1 exactly when `shift_ir` or `shift_dr` was high at that edge. While Shift-IR is active, TDO carries the instruction shift register; otherwise it carries the selected data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tlr | input | 1 | State machine is in test-logic-reset |
| capture_ir | input | 1 | Capture-IR state strobe |
| shift_ir | input | 1 | Shift-IR state strobe |
| update_ir | input | 1 | Update-IR state strobe |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| user_code | input | 32 | User-programmed identification word |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_sel | output | 1 | Boundary register is the selected data register |
| pin_mode | output | 2 | 00 system, 01 boundary-driven, 10 high impedance |

## Verification
Every instruction code is loaded through a full capture, shift and update sequence, and each is followed by a data scan. The scan's output separates the three serial paths: the fixed identification word, the user word, the TDI pattern delayed by one bit behind a leading 0, or the inverted boundary stream that the bench drives on `bsr_so`. The same sequences separate clamp from external test and from float, which share a path or a pin mode with other codes but not both. A test-logic-reset strobe and a mid-run asynchronous reset each show that the identify code is restored. Sampling `pin_mode` between shift and update shows that a shifted instruction does not take effect early.

// File: rtl/tapdec_pkg.sv
package tapdec_pkg;

   localparam int unsigned OPC_W = 4;

   localparam logic [OPC_W-1:0] OP_EXTEST   = 4'b0000;
   localparam logic [OPC_W-1:0] OP_SAMPLE   = 4'b0001;
   localparam logic [OPC_W-1:0] OP_IDCODE   = 4'b0010;
   localparam logic [OPC_W-1:0] OP_USERCODE = 4'b0011;
   localparam logic [OPC_W-1:0] OP_CLAMP    = 4'b0100;
   localparam logic [OPC_W-1:0] OP_HIGHZ    = 4'b0101;

   typedef enum logic [1:0] {
      PM_SYSTEM   = 2'b00,
      PM_BOUNDARY = 2'b01,
      PM_FLOAT    = 2'b10
   } pin_mode_e;

   typedef enum logic [1:0] {
      PATH_BYPASS   = 2'b00,
      PATH_IDENT    = 2'b01,
      PATH_BOUNDARY = 2'b10
   } dr_path_e;

   typedef struct packed {
      dr_path_e  path;
      pin_mode_e pins;
      logic      user_id;
   } insn_ctrl_t;

endpackage

// File: rtl/tapdec_ir.sv
module tapdec_ir
   import tapdec_pkg::*;
#(
   parameter int unsigned IR_W         = 4,
   parameter int unsigned HAS_USERCODE = 1
) (
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tlr,
   input  logic       capture_ir,
   input  logic       shift_ir,
   input  logic       update_ir,
   input  logic       tdi,
   output logic       ir_lsb,
   output insn_ctrl_t ctrl
);

   localparam logic [IR_W-1:0] RESET_OP    = IR_W'(OP_IDCODE);
   localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(2'b01);
   localparam bit              USR_EN      = (HAS_USERCODE != 0);

   if (IR_W < OPC_W) begin : g_width_bad
      $error("tapdec_ir: IR_W must be at least %0d", OPC_W);
   end
   if (HAS_USERCODE > 1) begin : g_opt_bad
      $error("tapdec_ir: HAS_USERCODE must be 0 or 1");
   end

   logic [IR_W-1:0]  sr_q;
   logic [IR_W-1:0]  act_q;
   logic [OPC_W-1:0] lo_op;
   logic             hi_zero;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr_q  <= '0;
         act_q <= RESET_OP;
      end else begin
         if (capture_ir)
            sr_q <= CAPTURE_PAT;
         else if (shift_ir)
            sr_q <= {tdi, sr_q[IR_W-1:1]};
         if (tlr)
            act_q <= RESET_OP;
         else if (update_ir)
            act_q <= sr_q;
      end
   end

   assign ir_lsb = sr_q[0];
   assign lo_op  = act_q[OPC_W-1:0];

   // wider registers: any set upper bit makes the code unassigned
   if (IR_W > OPC_W) begin : g_wide
      assign hi_zero = ~|act_q[IR_W-1:OPC_W];
   end else begin : g_exact
      assign hi_zero = 1'b1;
   end

   always_comb begin
      ctrl.path    = PATH_BYPASS;
      ctrl.pins    = PM_SYSTEM;
      ctrl.user_id = 1'b0;
      if (hi_zero) begin
         case (lo_op)
            OP_EXTEST: begin
               ctrl.path = PATH_BOUNDARY;
               ctrl.pins = PM_BOUNDARY;
            end
            OP_SAMPLE:   ctrl.path = PATH_BOUNDARY;
            OP_IDCODE:   ctrl.path = PATH_IDENT;
            OP_USERCODE: begin
               if (USR_EN) begin
                  ctrl.path    = PATH_IDENT;
                  ctrl.user_id = 1'b1;
               end
            end
            OP_CLAMP:    ctrl.pins = PM_BOUNDARY;
            OP_HIGHZ:    ctrl.pins = PM_FLOAT;
            default:     ctrl.path = PATH_BYPASS;
         endcase
      end
   end

   // R2
   ir_capture_pat_chk: assert property (@(posedge tck) disable iff (!trst_n)
      capture_ir |=> sr_q[1:0] == 2'b01);
   // R2
   ir_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (update_ir && !tlr) |=> act_q == $past(sr_q));
   // R2
   ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (!update_ir && !tlr) |=> $stable(act_q));
   // R1
   ir_tlr_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tlr |=> act_q == RESET_OP);

endmodule

// File: rtl/tapdec_idreg.sv
module tapdec_idreg #(
   parameter logic [3:0]  ID_VERSION = 4'h1,
   parameter logic [15:0] ID_PART    = 16'h0001,
   parameter logic [10:0] ID_MAKER   = 11'h001
) (
   input  logic        tck,
   input  logic        trst_n,
   input  logic        sel,
   input  logic        use_user,
   input  logic        capture_dr,
   input  logic        shift_dr,
   input  logic        tdi,
   input  logic [31:0] user_code,
   output logic        so
);

   localparam int unsigned   ID_W    = 32;
   localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

   logic [ID_W-1:0] id_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         id_q <= ID_WORD;
      else if (sel && capture_dr)
         id_q <= use_user ? user_code : ID_WORD;
      else if (sel && shift_dr)
         id_q <= {tdi, id_q[ID_W-1:1]};
   end

   assign so = id_q[0];

   // R4
   id_fixed_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && capture_dr && !use_user) |=> id_q == ID_WORD);
   // R5
   id_user_cap_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && capture_dr && use_user) |=> id_q == $past(user_code));
   // R4
   id_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && shift_dr && !capture_dr) |=> id_q[ID_W-1] == $past(tdi));

endmodule

// File: rtl/tapdec_bypass.sv
module tapdec_bypass (
   input  logic tck,
   input  logic trst_n,
   input  logic sel,
   input  logic capture_dr,
   input  logic shift_dr,
   input  logic tdi,
   output logic so
);

   logic byp_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)
         byp_q <= 1'b0;
      else if (sel && capture_dr)
         byp_q <= 1'b0;
      else if (sel && shift_dr)
         byp_q <= tdi;
   end

   assign so = byp_q;

   // R3
   byp_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && capture_dr) |=> !so);
   // R3
   byp_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel && shift_dr && !capture_dr) |=> so == $past(tdi));
   // R3
   byp_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      !(sel && (capture_dr || shift_dr)) |=> $stable(so));

endmodule

// File: rtl/tapdec_top.sv
module tapdec_top
   import tapdec_pkg::*;
#(
   parameter int unsigned IR_W         = 4,
   parameter int unsigned HAS_USERCODE = 1,
   parameter logic [3:0]  ID_VERSION   = 4'h1,
   parameter logic [15:0] ID_PART      = 16'h0001,
   parameter logic [10:0] ID_MAKER     = 11'h001
) (
   input  logic        tck,
   input  logic        trst_n,
   input  logic        tlr,
   input  logic        capture_ir,
   input  logic        shift_ir,
   input  logic        update_ir,
   input  logic        capture_dr,
   input  logic        shift_dr,
   input  logic        tdi,
   input  logic        bsr_so,
   input  logic [31:0] user_code,
   output logic        tdo,
   output logic        tdo_oe,
   output logic        bsr_sel,
   output logic [1:0]  pin_mode
);

   insn_ctrl_t ctrl;
   logic       ir_lsb;
   logic       id_so;
   logic       byp_so;
   logic       dr_out;
   logic       tdo_q;
   logic       oe_q;

   tapdec_ir #(
      .IR_W         (IR_W),
      .HAS_USERCODE (HAS_USERCODE)
   ) u_ir (
      .tck        (tck),
      .trst_n     (trst_n),
      .tlr        (tlr),
      .capture_ir (capture_ir),
      .shift_ir   (shift_ir),
      .update_ir  (update_ir),
      .tdi        (tdi),
      .ir_lsb     (ir_lsb),
      .ctrl       (ctrl)
   );

   tapdec_idreg #(
      .ID_VERSION (ID_VERSION),
      .ID_PART    (ID_PART),
      .ID_MAKER   (ID_MAKER)
   ) u_id (
      .tck        (tck),
      .trst_n     (trst_n),
      .sel        (ctrl.path == PATH_IDENT),
      .use_user   (ctrl.user_id),
      .capture_dr (capture_dr),
      .shift_dr   (shift_dr),
      .tdi        (tdi),
      .user_code  (user_code),
      .so         (id_so)
   );

   tapdec_bypass u_byp (
      .tck        (tck),
      .trst_n     (trst_n),
      .sel        (ctrl.path == PATH_BYPASS),
      .capture_dr (capture_dr),
      .shift_dr   (shift_dr),
      .tdi        (tdi),
      .so         (byp_so)
   );

   always_comb begin
      case (ctrl.path)
         PATH_IDENT:    dr_out = id_so;
         PATH_BOUNDARY: dr_out = bsr_so;
         default:       dr_out = byp_so;
      endcase
   end

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q  <= shift_ir | shift_dr;
         tdo_q <= shift_ir ? ir_lsb : dr_out;
      end
   end

   assign tdo      = tdo_q;
   assign tdo_oe   = oe_q;
   assign bsr_sel  = (ctrl.path == PATH_BOUNDARY);
   assign pin_mode = ctrl.pins;

   // R9
   oe_on_chk: assert property (@(negedge tck) disable iff (!trst_n)
      (shift_ir || shift_dr) |=> tdo_oe);
   // R9
   oe_off_chk: assert property (@(negedge tck) disable iff (!trst_n)
      !(shift_ir || shift_dr) |=> !tdo_oe);
   // R6
   pin_code_chk: assert property (@(posedge tck) disable iff (!trst_n)
      pin_mode != 2'b11);
   // R8
   float_excl_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (pin_mode == 2'b10) |-> !bsr_sel);

endmodule

// File: tb/test_tapdec_top.sv
module test_tapdec_top;

   localparam int          CLK_PERIOD = 10;
   localparam logic [3:0]  VER  = 4'h3;
   localparam logic [15:0] PART = 16'hB52E;
   localparam logic [10:0] MAK  = 11'h0E5;
   localparam logic [31:0] IDW  = {VER, PART, MAK, 1'b1};

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tlr = 1'b0, capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
   logic        capture_dr = 1'b0, shift_dr = 1'b0, tdi = 1'b0, bsr_so = 1'b0;
   logic [31:0] user_code = 32'h1234_5678;
   logic        tdo, tdo_oe, bsr_sel;
   logic [1:0]  pin_mode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   tapdec_top #(
      .IR_W(4), .HAS_USERCODE(1),
      .ID_VERSION(VER), .ID_PART(PART), .ID_MAKER(MAK)
   ) i_tapdec_top (
      .tck(tck), .trst_n(trst_n), .tlr(tlr),
      .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .tdi(tdi),
      .bsr_so(bsr_so), .user_code(user_code),
      .tdo(tdo), .tdo_oe(tdo_oe), .bsr_sel(bsr_sel), .pin_mode(pin_mode)
   );

   always #(CLK_PERIOD/2) tck = ~tck;

   // ---------------- behavioural reference model ----------------
   int       m_act, m_irs;
   bit [31:0] m_id;
   bit       m_byp, m_tdo, m_oe;

   // path: 0 single bit, 1 ident, 2 boundary; pins: 0 sys, 1 boundary, 2 float
   function automatic int mpath(int op);
      case (op)
         0, 1: return 2;
         2, 3: return 1;
         default: return 0;
      endcase
   endfunction
   function automatic int mpins(int op);
      case (op)
         0, 4: return 1;
         5: return 2;
         default: return 0;
      endcase
   endfunction

   always @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         m_act = 2; m_irs = 0; m_id = IDW; m_byp = 1'b0;
      end else begin
         if (capture_dr) begin
            if (mpath(m_act) == 1) m_id = (m_act == 3) ? user_code : IDW;
            if (mpath(m_act) == 0) m_byp = 1'b0;
         end else if (shift_dr) begin
            if (mpath(m_act) == 1) m_id = {tdi, m_id[31:1]};
            if (mpath(m_act) == 0) m_byp = tdi;
         end
         if (capture_ir) m_irs = 1;
         else if (shift_ir) m_irs = (m_irs >> 1) | (int'(tdi) << 3);
         if (tlr) m_act = 2;
         else if (update_ir) m_act = m_irs;
      end
   end

   always @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         m_tdo = 1'b0; m_oe = 1'b0;
      end else begin
         m_oe = shift_ir | shift_dr;
         if (shift_ir) m_tdo = m_irs[0];
         else if (mpath(m_act) == 1) m_tdo = m_id[0];
         else if (mpath(m_act) == 2) m_tdo = bsr_so;
         else m_tdo = m_byp;
      end
   end

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from both edges
   always @(negedge tck) begin
      #2;
      if (trst_n && !done) begin
         check("R9 tdo_oe", {63'd0, tdo_oe}, {63'd0, m_oe});
         if (m_oe) check("R9 tdo", {63'd0, tdo}, {63'd0, m_tdo});
         if (m_act == 4)      check("R7 pin_mode", {62'd0, pin_mode}, 64'(mpins(m_act)));
         else if (m_act == 5) check("R8 pin_mode", {62'd0, pin_mode}, 64'(mpins(m_act)));
         else                 check("R6 pin_mode", {62'd0, pin_mode}, 64'(mpins(m_act)));
         check("R6 bsr_sel", {63'd0, bsr_sel}, {63'd0, mpath(m_act) == 2});
      end
   end

   // ---------------- stimulus ----------------
   task automatic step();
      @(posedge tck); #1;
   endtask

   task automatic load_ir(input logic [3:0] code, output logic [3:0] shout);
      logic [1:0] pm_before;
      pm_before = pin_mode;
      capture_ir = 1'b1; step(); capture_ir = 1'b0;
      shift_ir = 1'b1;
      for (int i = 0; i < 4; i++) begin
         tdi = code[i];
         @(negedge tck); #3; shout[i] = tdo;
         @(posedge tck); #1;
      end
      shift_ir = 1'b0; tdi = 1'b0;
      check("R2 pins held before update", {62'd0, pin_mode}, {62'd0, pm_before});
      update_ir = 1'b1; step(); update_ir = 1'b0;
      step();
   endtask

   task automatic dr_scan(input logic [63:0] din, input int n, output logic [63:0] dout);
      dout = '0;
      capture_dr = 1'b1; step(); capture_dr = 1'b0;
      shift_dr = 1'b1;
      for (int i = 0; i < n; i++) begin
         tdi = din[i]; bsr_so = ~din[i];
         @(negedge tck); #3; dout[i] = tdo;
         if (i == 0) check("R9 oe during shift", {63'd0, tdo_oe}, 64'd1);
         @(posedge tck); #1;
      end
      shift_dr = 1'b0; tdi = 1'b0; bsr_so = 1'b0;
      step();
      check("R9 oe idle", {63'd0, tdo_oe}, 64'd0);
   endtask

   initial begin
      logic [3:0]  irout;
      logic [63:0] dout;
      localparam logic [63:0] PAT = 64'h0000_0000_0000_00B3;
      repeat (3) step();
      check("R1 reset tdo_oe", {63'd0, tdo_oe}, 64'd0);
      check("R1 reset pin_mode", {62'd0, pin_mode}, 64'd0);
      check("R1 reset bsr_sel", {63'd0, bsr_sel}, 64'd0);
      trst_n = 1'b1;
      step();

      // identify selected straight after reset
      dr_scan(64'h0, 32, dout);
      check("R1 R4 id after reset", dout, {32'd0, IDW});

      // external test
      load_ir(4'b0000, irout);
      check("R2 ir capture pattern", {60'd0, irout}, 64'h1);
      check("R6 extest pins", {62'd0, pin_mode}, 64'd1);
      check("R6 extest sel", {63'd0, bsr_sel}, 64'd1);
      dr_scan(PAT, 8, dout);
      check("R6 extest tdo from bsr_so", dout, {56'd0, ~PAT[7:0]});

      // sample
      load_ir(4'b0001, irout);
      check("R6 sample pins", {62'd0, pin_mode}, 64'd0);
      check("R6 sample sel", {63'd0, bsr_sel}, 64'd1);
      dr_scan(64'h5A, 8, dout);
      check("R6 sample tdo from bsr_so", dout, 64'hA5);

      // clamp
      load_ir(4'b0100, irout);
      check("R7 clamp pins", {62'd0, pin_mode}, 64'd1);
      check("R7 clamp sel", {63'd0, bsr_sel}, 64'd0);
      dr_scan(PAT, 8, dout);
      check("R7 clamp single-bit path", dout, {56'd0, PAT[6:0], 1'b0});

      // float
      load_ir(4'b0101, irout);
      check("R8 float pins", {62'd0, pin_mode}, 64'd2);
      dr_scan(PAT, 8, dout);
      check("R8 float single-bit path", dout, {56'd0, PAT[6:0], 1'b0});

      // bypass and an unassigned code
      load_ir(4'b1111, irout);
      check("R3 bypass pins", {62'd0, pin_mode}, 64'd0);
      dr_scan(64'hE7, 8, dout);
      check("R3 bypass path", dout, 64'hCE);
      load_ir(4'b1010, irout);
      check("R3 unassigned sel", {63'd0, bsr_sel}, 64'd0);
      dr_scan(64'h6D, 8, dout);
      check("R3 unassigned path", dout, 64'hDA);

      // user code
      load_ir(4'b0011, irout);
      dr_scan(64'h0, 32, dout);
      check("R5 user word", dout, {32'd0, user_code});
      user_code = 32'hFACE_0B0E;
      dr_scan(64'h0, 32, dout);
      check("R5 user word change", dout, {32'd0, 32'hFACE_0B0E});

      // identify explicitly
      load_ir(4'b0010, irout);
      dr_scan(64'hFFFF_FFFF, 32, dout);
      check("R4 id word", dout, {32'd0, IDW});

      // test-logic-reset strobe
      load_ir(4'b0000, irout);
      tlr = 1'b1; step(); tlr = 1'b0; step();
      check("R1 tlr pins", {62'd0, pin_mode}, 64'd0);
      dr_scan(64'h0, 32, dout);
      check("R1 tlr id", dout, {32'd0, IDW});

      // asynchronous reset mid-run
      load_ir(4'b0101, irout);
      #2 trst_n = 1'b0; #1;
      check("R1 async pins", {62'd0, pin_mode}, 64'd0);
      step(); trst_n = 1'b1; step();
      dr_scan(64'h0, 32, dout);
      check("R1 async id", dout, {32'd0, IDW});

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule